// File: doc/BRIEF.md
# Multichannel PDM Edge Sampler

This block captures one-bit pulse-density microphone streams in a fast system clock domain. It generates the microphone bit clock by dividing the system clock. It watches that clock come back through a two-flop synchronizer and, for each channel, counts system clocks from the most recent bit-clock edge. A channel latches its data line when that count equals the channel's own programmable sample pointer. Software normally sets the pointer to about three quarters of the half period, which is ceil(f_sys / (2 * f_bit)) * 3 / 4.

Channels come in pairs on one data line. The even channel of a pair samples in the half period that follows a rising bit-clock edge. The odd channel samples in the half period that follows a falling edge. Each capture updates the channel's sample bit and raises that channel's valid strobe for one cycle, so every enabled channel yields one bit per bit-clock period. A small write-only configuration port holds the following settings:

- a global run bit
- per-channel enable and active-low reset masks
- the packed pointers
- the half-period length of the divider

Top module: `pdm_edge_sampler`

## Requirements
- R1: After rst_ni is asserted, pdm_clk_o, smp_o and smp_vld_o are all zero and every configuration field is zero, so no strobe occurs until the block is configured.
- R2: Address 3 bits [7:0] set the half period H in system clocks. While the run bit (address 0 bit 31) is set, pdm_clk_o toggles every H system clocks, giving a period of 2H. While the run bit is clear, pdm_clk_o is held low.
- R3: With the default two-stage synchronizer, an even channel's strobe appears pointer+4 system clocks after pdm_clk_o rises. An odd channel's strobe appears pointer+4 system clocks after pdm_clk_o falls.
- R4: On a capture, smp_o[i] takes the value of pdm_dat_i[i/2]. smp_o[i] holds that value until the next capture of channel i or until channel i is reset.
- R5: Pointers are 8 bits wide. Address 1 holds channels 0 to 3 and address 2 holds channels 4 to 7, with channel i in bits [8(i%4)+7 : 8(i%4)].
- R6: A channel that is enabled, out of reset and running strobes exactly once per bit-clock period, and each strobe lasts one cycle.
- R7: A pointer equal to or larger than H produces no strobe for that channel.
- R8: Address 0 bits [7:0] are channel enables. A channel whose enable bit is 0 gives no strobe, and its smp_o bit keeps its last value.
- R9: Address 0 bits [15:8] are active-low channel resets. A channel whose bit is 0 has its smp_o bit cleared and gives no strobe.
- R10: Clearing the run bit stops all strobes from the next cycle on. This includes any capture that the final forced falling edge of the bit clock would otherwise trigger.
- R11: A pointer of H-1 makes the capture fall in the same cycle in which the next bit-clock edge restarts the counter. The capture is still taken, at offset H+3 from the channel's own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word address: 0 control, 1 and 2 pointers, 3 divider |
| cfg_wdata_i | input | 32 | Configuration write data |
| pdm_clk_o | output | 1 | Divided bit clock to the microphones |
| pdm_dat_i | input | 4 | One data line per channel pair |
| smp_o | output | 8 | Latest captured bit per channel |
| smp_vld_o | output | 8 | One-cycle capture strobe per channel |

## Verification
The sharpest coincidence is a channel's pointer match landing in the same cycle as the bit-clock edge that restarts its counter. Setting a pointer of H-1 on one even channel and one odd channel provokes it, and the bench judges it by the strobe offset (H+3) and by exactly one strobe per period. A second overlap arises when the run bit is cleared while the bit clock is high. The forced falling edge then reaches the odd channels after capture has been gated off, and the bench expects zero strobes from that edge on.

// File: rtl/pdm_edge_pkg.sv
package pdm_edge_pkg;
  localparam int unsigned CFG_W      = 32;
  localparam int unsigned RUN_BIT    = 31;
  localparam int unsigned RSTN_LSB   = 8;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/pdm_cfg_regs.sv
module pdm_cfg_regs #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned CFG_W  = 32,
  parameter int unsigned AW     = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [CFG_W-1:0]              wdata_i,
  output logic                          run_o,
  output logic [NUM_CH-1:0]             ch_en_o,
  output logic [NUM_CH-1:0]             ch_rstn_o,
  output logic [NUM_CH-1:0][PTR_W-1:0]  ptr_o,
  output logic [PTR_W-1:0]              half_o
);
  import pdm_edge_pkg::*;

  localparam int unsigned PER_WORD = CFG_W / PTR_W;
  localparam int unsigned WORDS    = (NUM_CH + PER_WORD - 1) / PER_WORD;
  localparam int unsigned DIV_ADDR = WORDS + 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o     <= 1'b0;
      ch_en_o   <= '0;
      ch_rstn_o <= '0;
      half_o    <= '0;
    end else if (we_i) begin
      if (addr_i == '0) begin
        run_o     <= wdata_i[RUN_BIT];
        ch_en_o   <= wdata_i[NUM_CH-1:0];
        ch_rstn_o <= wdata_i[RSTN_LSB +: NUM_CH];
      end
      if (addr_i == AW'(DIV_ADDR)) half_o <= wdata_i[PTR_W-1:0];
    end
  end

  // pointer words: channel c sits in word c/PER_WORD, slot c%PER_WORD
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (we_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr_i == AW'(1 + c / PER_WORD))
          ptr_o[c] <= wdata_i[(c % PER_WORD) * PTR_W +: PTR_W];
      end
    end
  end
endmodule

// File: rtl/pdm_bclk_gen.sv
module pdm_bclk_gen #(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PTR_W-1:0] half_i,
  output logic             bclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [PTR_W-1:0] div_cnt;
  logic [SYNC:0]    sh;
  logic             wrap;

  assign wrap = ({1'b0, div_cnt} + {{PTR_W{1'b0}}, 1'b1}) >= {1'b0, half_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      bclk_o  <= 1'b0;
    end else if (!run_i) begin
      div_cnt <= '0;
      bclk_o  <= 1'b0;
    end else if (wrap) begin
      div_cnt <= '0;
      bclk_o  <= ~bclk_o;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // clock returns through a synchronizer, last stage kept for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[SYNC-1:0], bclk_o};
  end

  assign rise_o =  sh[SYNC-1] & ~sh[SYNC];
  assign fall_o = ~sh[SYNC-1] &  sh[SYNC];
endmodule

// File: rtl/pdm_chan.sv
module pdm_chan #(
  parameter int unsigned PTR_W = 8,
  parameter bit          ODD   = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             rstn_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             dat_i,
  output logic             smp_o,
  output logic             vld_o
);
  logic [PTR_W-1:0] cnt;
  logic             armed;
  logic             own_edge;
  logic             hit;

  assign own_edge = ODD ? fall_i : rise_i;
  // compare uses the count before any restart in this cycle
  assign hit = run_i && rstn_i && en_i && armed &&
               (cnt == ptr_i) && (cnt != '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '1;
      armed <= 1'b0;
    end else if (!run_i || !rstn_i) begin
      cnt   <= '1;
      armed <= 1'b0;
    end else if (rise_i || fall_i) begin
      cnt   <= '0;
      armed <= own_edge;
    end else if (cnt != '1) begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= hit;
      if (!rstn_i)  smp_o <= 1'b0;
      else if (hit) smp_o <= dat_i;
    end
  end
endmodule

// File: rtl/pdm_edge_sampler.sv
module pdm_edge_sampler #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PTR_W  = 8,
  localparam int unsigned LINES    = (NUM_CH + 1) / 2,
  localparam int unsigned PER_WORD = pdm_edge_pkg::CFG_W / PTR_W,
  localparam int unsigned WORDS    = (NUM_CH + PER_WORD - 1) / PER_WORD,
  localparam int unsigned AW       = $clog2(WORDS + 2)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [AW-1:0]                 cfg_addr_i,
  input  logic [pdm_edge_pkg::CFG_W-1:0] cfg_wdata_i,
  output logic                          pdm_clk_o,
  input  logic [LINES-1:0]              pdm_dat_i,
  output logic [NUM_CH-1:0]             smp_o,
  output logic [NUM_CH-1:0]             smp_vld_o
);
  import pdm_edge_pkg::*;

  logic                         run;
  logic [NUM_CH-1:0]            ch_en;
  logic [NUM_CH-1:0]            ch_rstn;
  logic [NUM_CH-1:0][PTR_W-1:0] ptr;
  logic [PTR_W-1:0]             half;
  logic                         rise;
  logic                         fall;

  pdm_cfg_regs #(
    .NUM_CH(NUM_CH), .PTR_W(PTR_W), .CFG_W(CFG_W), .AW(AW)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .run_o(run), .ch_en_o(ch_en), .ch_rstn_o(ch_rstn),
    .ptr_o(ptr), .half_o(half)
  );

  pdm_bclk_gen #(.PTR_W(PTR_W), .SYNC(SYNC_DEPTH)) u_bclk (
    .clk_i, .rst_ni, .run_i(run), .half_i(half),
    .bclk_o(pdm_clk_o), .rise_o(rise), .fall_o(fall)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pdm_chan #(.PTR_W(PTR_W), .ODD(i % 2)) u_ch (
      .clk_i, .rst_ni,
      .run_i(run), .en_i(ch_en[i]), .rstn_i(ch_rstn[i]), .ptr_i(ptr[i]),
      .rise_i(rise), .fall_i(fall), .dat_i(pdm_dat_i[i/2]),
      .smp_o(smp_o[i]), .vld_o(smp_vld_o[i])
    );
  end
endmodule

// File: rtl/pdm_edge_sampler_chk.sv
module pdm_edge_sampler_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic [NUM_CH-1:0] ch_en_i,
  input logic [NUM_CH-1:0] ch_rstn_i,
  input logic              bclk_i,
  input logic [NUM_CH-1:0] smp_i,
  input logic [NUM_CH-1:0] vld_i
);
  // R2
  bclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !bclk_i);

  // R10
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (vld_i == '0));

  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vld_i) |=> ((vld_i & $past(vld_i)) == '0));

  // R8
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i & ~$past(ch_en_i)) == '0);

  // R9
  rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i & ~$past(ch_rstn_i)) == '0);
endmodule

bind pdm_edge_sampler pdm_edge_sampler_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .ch_en_i(ch_en),
  .ch_rstn_i(ch_rstn), .bclk_i(pdm_clk_o), .smp_i(smp_o), .vld_i(smp_vld_o)
);

// File: tb/pdm_edge_sampler_test.sv
module pdm_edge_sampler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        pdm_clk;
  logic [3:0]  dat = '0;
  logic [7:0]  smp, vld;

  logic [3:0] hi_pat = '0, lo_pat = '0;
  int cyc = 0, n_chk = 0, n_err = 0;
  int last_rise = 0, last_fall = 0;
  int stb_cnt[8];
  int last_off[8];
  bit bclk_prev = 1'b0;
  bit done = 1'b0;

  localparam int H = 20;

  pdm_edge_sampler uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .pdm_clk_o(pdm_clk), .pdm_dat_i(dat),
    .smp_o(smp), .smp_vld_o(vld)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // observer
  always @(negedge clk) begin
    if (pdm_clk && !bclk_prev) last_rise = cyc;
    if (!pdm_clk && bclk_prev) last_fall = cyc;
    bclk_prev = pdm_clk;
    for (int i = 0; i < 8; i++) begin
      if (vld[i]) begin
        stb_cnt[i]++;
        last_off[i] = cyc - ((i % 2) ? last_fall : last_rise);
      end
    end
  end

  // microphone model: one pattern in the high half, another in the low half
  initial forever begin
    @(negedge clk);
    dat = pdm_clk ? hi_pat : lo_pat;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_w(input bit g, input logic [7:0] en, input logic [7:0] rn);
    return {g, 15'd0, rn, en};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_rise();
    bit p;
    p = pdm_clk;
    forever begin
      @(negedge clk);
      if (pdm_clk && !p) break;
      p = pdm_clk;
    end
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < 8; i++) stb_cnt[i] = 0;
  endtask

  task automatic t_reset();
    chk(pdm_clk == 1'b0, "R1 clk", int'(pdm_clk), 0);
    chk(vld == 8'h00, "R1 vld", int'(vld), 0);
    chk(smp == 8'h00, "R1 smp", int'(smp), 0);
    clr_cnt();
    repeat (60) @(negedge clk);
    chk(stb_cnt.sum() == 0 && pdm_clk == 1'b0, "R1 idle", stb_cnt.sum(), 0);
  endtask

  task automatic t_divider();
    int r0, f0;
    wr(2'd3, H);
    wr(2'd1, 32'h06050403);
    wr(2'd2, 32'h0A090807);
    wr(2'd0, ctrl_w(1'b1, 8'hFF, 8'hFF));
    wait_rise();
    r0 = cyc;
    @(negedge clk);
    while (pdm_clk) @(negedge clk);
    f0 = cyc;
    wait_rise();
    chk(f0 - r0 == H, "R2 high", f0 - r0, H);
    chk(cyc - r0 == 2 * H, "R2 period", cyc - r0, 2 * H);
  endtask

  task automatic t_timing();
    repeat (3) wait_rise();
    // R3 R5: channel i pointer 3+i across both pointer words
    for (int i = 0; i < 8; i++)
      chk(last_off[i] == i + 7, $sformatf("R3/R5 ch%0d offset", i), last_off[i], i + 7);
  endtask

  task automatic t_data(input logic [3:0] a, input logic [3:0] b);
    logic [7:0] exp;
    hi_pat = a; lo_pat = b;
    repeat (3) wait_rise();
    for (int i = 0; i < 8; i++) exp[i] = (i % 2) ? b[i/2] : a[i/2];
    chk(smp == exp, "R4 data", int'(smp), int'(exp));
  endtask

  task automatic t_count();
    wait_rise();
    clr_cnt();
    repeat (5) wait_rise();
    for (int i = 0; i < 8; i++)
      chk(stb_cnt[i] == 5, $sformatf("R6 ch%0d count", i), stb_cnt[i], 5);
  endtask

  task automatic t_far();
    wr(2'd1, 32'h06051914);
    wait_rise(); wait_rise();
    clr_cnt();
    repeat (5) wait_rise();
    chk(stb_cnt[0] == 0, "R7 ch0 ptr=H", stb_cnt[0], 0);
    chk(stb_cnt[1] == 0, "R7 ch1 ptr>H", stb_cnt[1], 0);
    chk(stb_cnt[2] == 5, "R7 ch2 normal", stb_cnt[2], 5);
  endtask

  task automatic t_edge();
    wr(2'd1, 32'h13130403);
    wait_rise(); wait_rise();
    clr_cnt();
    repeat (5) wait_rise();
    chk(stb_cnt[2] == 5, "R11 ch2 count", stb_cnt[2], 5);
    chk(stb_cnt[3] == 5, "R11 ch3 count", stb_cnt[3], 5);
    chk(last_off[2] == H + 3, "R11 ch2 offset", last_off[2], H + 3);
    chk(last_off[3] == H + 3, "R11 ch3 offset", last_off[3], H + 3);
    wr(2'd1, 32'h06050403);
  endtask

  task automatic t_chan_en();
    // smp[0]==1 from previous pattern; now drive zeros with ch0 disabled
    wr(2'd0, ctrl_w(1'b1, 8'hFE, 8'hFF));
    wait_rise();
    clr_cnt();
    hi_pat = 4'h0; lo_pat = 4'h0;
    repeat (4) wait_rise();
    chk(stb_cnt[0] == 0, "R8 ch0 strobes", stb_cnt[0], 0);
    chk(smp[0] == 1'b1, "R8 ch0 held", int'(smp[0]), 1);
    chk(smp[2] == 1'b0, "R8 ch2 updates", int'(smp[2]), 0);
  endtask

  task automatic t_chan_rst();
    hi_pat = 4'hF; lo_pat = 4'hF;
    repeat (2) wait_rise();
    chk(smp[1] == 1'b1, "R9 ch1 before", int'(smp[1]), 1);
    wr(2'd0, ctrl_w(1'b1, 8'hFF, 8'hFD));
    clr_cnt();
    repeat (4) wait_rise();
    chk(smp[1] == 1'b0, "R9 ch1 cleared", int'(smp[1]), 0);
    chk(stb_cnt[1] == 0, "R9 ch1 strobes", stb_cnt[1], 0);
    chk(stb_cnt[3] == 4, "R9 ch3 unaffected", stb_cnt[3], 4);
  endtask

  task automatic t_global();
    int hi_seen;
    wait_rise();
    repeat (14) @(negedge clk);
    wr(2'd0, ctrl_w(1'b0, 8'hFF, 8'hFF));
    clr_cnt();
    hi_seen = 0;
    repeat (120) begin
      @(negedge clk);
      if (pdm_clk) hi_seen++;
    end
    chk(stb_cnt.sum() == 0, "R10 no strobes", stb_cnt.sum(), 0);
    chk(hi_seen == 0, "R2 clk held low", hi_seen, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin stb_cnt[i] = 0; last_off[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divider();
    t_timing();
    t_data(4'b1010, 4'b0110);
    t_data(4'b0101, 4'b1001);
    t_count();
    t_far();
    t_edge();
    t_chan_en();
    t_chan_rst();
    t_global();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule